// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode. It receives one 32-bit fetched word. When the two low bits of that word show a 16-bit compressed instruction, the block rewrites the low halfword into the equivalent full-length base-ISA encoding. Any other word goes through unchanged. The block is purely combinational. It reports the expanded word, the byte length of the original instruction and a flag for encodings that are reserved or have forbidden operands.

A width parameter selects a 32-bit or a 64-bit register file. This choice changes what several compressed opcode slots mean. In the 32-bit build those slots carry single-precision float loads and stores and the short link-jump. In the 64-bit build they carry doubleword integer loads and stores, the word-sized add-immediate and the word-sized add and subtract. Double-precision float loads and stores exist in both builds. Downstream decode sees only full-length encodings and the illegal flag.

Top module: `cinst_expand`

## Requirements
- R1: A word whose bits [1:0] are 2'b11 appears on the output unchanged, with length 4 and the illegal flag low.
- R2: Any other word reports length 2, and bits [31:16] of the input have no effect. A legal expansion always has bits [1:0] = 2'b11. An illegal one drives an all-zero word. Quadrant 0 slot funct3 = 100 is illegal.
- R3: A 3-bit compressed register field r names register x(8+r), in both source and destination positions.
- R4: The quadrant 0 stack-relative add (funct3 000) takes its unsigned immediate from bits [10:7]→[9:6], [12:11]→[5:4], bit 5→3 and bit 6→2. It becomes ADDI with rs1 = x2. An all-zero immediate is illegal.
- R5: Quadrant 0 and quadrant 2 slots funct3 011 and 111 give single-precision float load/store (funct3 010, opcodes 0000111/0100111) when XLEN = 32. They give doubleword integer load/store (funct3 011, opcodes 0000011/0100011) when XLEN = 64.
- R6: In quadrant 1 with funct3 011, rd = x2 gives ADDI x2,x2 with a 10-bit signed immediate, and a zero immediate is illegal. Any other rd gives LUI with a sign-extended 6-bit upper immediate, and rd = x0 or a zero immediate is illegal.
- R7: The compressed jump offset (bit12→11, bit11→4, [10:9]→[9:8], bit8→10, bit7→6, bit6→7, [5:3]→[3:1], bit2→5) is sign-extended and packed as JAL. funct3 101 links to x0. In the 32-bit build funct3 001 links to x1. In the 64-bit build funct3 001 is ADDIW rd,rd, which is illegal for rd = x0.
- R8: The branch-on-zero forms (funct3 110 → BEQ, 111 → BNE) compare x(8+r) with x0. Their signed 9-bit offset comes from bit12→8, bits [6:5]→[7:6], bit2→5, [11:10]→[4:3] and [4:3]→[2:1].
- R9: In quadrant 2 with funct3 100 and bits [6:2] = 0: bit12 = 0 gives JALR x0 (illegal if rd = x0). bit12 = 1 gives 32'h00100073 when rd = x0, and JALR x1 otherwise. With bits [6:2] nonzero, bit12 = 0 gives a register move and bit12 = 1 gives ADD. Both are illegal for rd = x0.
- R10: In the quadrant 1 register-register group (bits [11:10] = 11) with bit12 = 1, the 64-bit build gives SUBW for op 00 and ADDW for op 01, and is illegal otherwise. The 32-bit build is always illegal.
- R11: The arithmetic right-shift immediate equals the logical right-shift encoding with bit 30 set. The shift amount is {bit12, bits[6:2]}.
- R12: A left-shift immediate and a stack-relative word load are illegal for rd = x0. So is the 64-bit stack-relative doubleword load.
- R13: Loads and stores scale their offsets by access size: word forms by 4, doubleword forms by 8. Stack-relative forms use base x2.
- R14: The remaining forms expand to their base equivalents: add-immediate, load-immediate (rs1 = x0), AND-immediate, and register SUB/XOR/OR/AND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cword_i | input | 32 | Fetched instruction word |
| xword_o | output | 32 | Expanded or passed-through instruction |
| len_o | output | 3 | Original instruction length in bytes (2 or 4) |
| bad_o | output | 1 | Reserved or illegal compressed encoding |

## Verification
The hardest cases to reach are the zero-operand traps. Each one rides on a single operand value inside an otherwise ordinary slot: a zero scaled immediate, rd = x0 or x2 in the LUI slot, and the gap between break and link-jump in the jump-register group. So do the slots whose meaning depends on the width parameter. Both builds sit side by side on the same stimulus. Every one of the 65,536 low-halfword patterns is driven, with a varying upper half. This reaches each of those single-value corners in both configurations and also checks that the upper half is ignored. An arithmetic model in the bench computes the expected word, and a short directed loop checks the compressed register mapping.

// File: rtl/cx_pkg.sv
package cx_pkg;

  localparam int unsigned ILEN = 32;
  localparam int unsigned CLEN = 16;
  localparam int unsigned RW   = 5;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMM32  = 7'b0011011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REG32  = 7'b0111011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_LOADF  = 7'b0000111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_STOREF = 7'b0100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BR     = 7'b1100011;
  localparam logic [ILEN-1:0] BREAK_WORD = 32'h0010_0073;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic            bad;
  } cx_res_t;

  function automatic logic [RW-1:0] cx_reg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [ILEN-1:0] mk_i(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                           input logic [2:0] f3, input logic [RW-1:0] rd,
                                           input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] mk_s(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                           input logic [RW-1:0] rs1, input logic [2:0] f3,
                                           input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [ILEN-1:0] mk_r(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                           input logic [RW-1:0] rs1, input logic [2:0] f3,
                                           input logic [RW-1:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] mk_u(input logic [19:0] imm, input logic [RW-1:0] rd,
                                           input logic [6:0] op);
    return {imm, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] mk_j(input logic [20:0] imm, input logic [RW-1:0] rd,
                                           input logic [6:0] op);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, op};
  endfunction

  function automatic logic [ILEN-1:0] mk_b(input logic [12:0] imm, input logic [RW-1:0] rs2,
                                           input logic [RW-1:0] rs1, input logic [2:0] f3,
                                           input logic [6:0] op);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], op};
  endfunction

endpackage

// File: rtl/cx_quad0.sv
module cx_quad0 import cx_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [CLEN-1:2] h,
  output cx_res_t         res
);
  localparam bit IS64 = (XLEN == 64);

  logic [RW-1:0] rp_lo, rp_hi;
  logic [11:0]   spn_imm, w_off, d_off;

  assign rp_lo   = cx_reg(h[4:2]);
  assign rp_hi   = cx_reg(h[9:7]);
  assign spn_imm = {2'b00, h[10:7], h[12:11], h[5], h[6], 2'b00};
  assign w_off   = {5'b0, h[5], h[12:10], h[6], 2'b00};
  assign d_off   = {4'b0, h[6:5], h[12:10], 3'b000};

  always_comb begin
    res = '{word: '0, bad: 1'b0};
    case (h[15:13])
      3'b000: if (spn_imm == '0) res.bad = 1'b1;
              else res.word = mk_i(spn_imm, 5'd2, 3'b000, rp_lo, OPC_IMM);
      3'b001: res.word = mk_i(d_off, rp_hi, 3'b011, rp_lo, OPC_LOADF);
      3'b010: res.word = mk_i(w_off, rp_hi, 3'b010, rp_lo, OPC_LOAD);
      3'b011: if (IS64) res.word = mk_i(d_off, rp_hi, 3'b011, rp_lo, OPC_LOAD);
              else      res.word = mk_i(w_off, rp_hi, 3'b010, rp_lo, OPC_LOADF);
      3'b101: res.word = mk_s(d_off, rp_lo, rp_hi, 3'b011, OPC_STOREF);
      3'b110: res.word = mk_s(w_off, rp_lo, rp_hi, 3'b010, OPC_STORE);
      3'b111: if (IS64) res.word = mk_s(d_off, rp_lo, rp_hi, 3'b011, OPC_STORE);
              else      res.word = mk_s(w_off, rp_lo, rp_hi, 3'b010, OPC_STOREF);
      default: res.bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      // R4: legal stack add keeps base x2 and a nonzero immediate
      p_spn_nonzero_r4: assert (h[15:13] != 3'b000 || res.bad ||
                                (res.word[19:15] == 5'd2 && res.word[31:20] != '0));
      // R3: every legal non-stack form in this quadrant uses a base in x8..x15
      p_base_window_r3: assert (h[15:13] == 3'b000 || res.bad || res.word[19:18] == 2'b01);
    end
  end

endmodule

// File: rtl/cx_quad1.sv
module cx_quad1 import cx_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [CLEN-1:2] h,
  output cx_res_t         res
);
  localparam bit IS64 = (XLEN == 64);

  logic [RW-1:0] rd, rp_d, rp_s;
  logic [5:0]    imm6;
  logic [11:0]   simm12, sp_imm12;
  logic [9:0]    sp_imm;
  logic [19:0]   up_imm;
  logic [20:0]   j_off;
  logic [12:0]   b_off;
  logic [ILEN-1:0] shr_word;

  assign rd       = h[11:7];
  assign rp_d     = cx_reg(h[9:7]);
  assign rp_s     = cx_reg(h[4:2]);
  assign imm6     = {h[12], h[6:2]};
  assign simm12   = {{6{h[12]}}, imm6};
  assign sp_imm   = {h[12], h[4:3], h[5], h[2], h[6], 4'b0000};
  assign sp_imm12 = {{2{h[12]}}, sp_imm};
  assign up_imm   = {{14{h[12]}}, imm6};
  assign j_off    = {{10{h[12]}}, h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
  assign b_off    = {{5{h[12]}}, h[6:5], h[2], h[11:10], h[4:3], 1'b0};
  assign shr_word = mk_i({6'b0, imm6}, rp_d, 3'b101, rp_d, OPC_IMM);

  always_comb begin
    res = '{word: '0, bad: 1'b0};
    case (h[15:13])
      3'b000: res.word = mk_i(simm12, rd, 3'b000, rd, OPC_IMM);
      3'b001: begin
        if (IS64) begin
          if (rd == '0) res.bad = 1'b1;
          else res.word = mk_i(simm12, rd, 3'b000, rd, OPC_IMM32);
        end else begin
          res.word = mk_j(j_off, 5'd1, OPC_JAL);
        end
      end
      3'b010: res.word = mk_i(simm12, 5'd0, 3'b000, rd, OPC_IMM);
      3'b011: begin
        if (rd == 5'd2) begin
          if (sp_imm == '0) res.bad = 1'b1;
          else res.word = mk_i(sp_imm12, 5'd2, 3'b000, 5'd2, OPC_IMM);
        end else if (rd == '0 || imm6 == '0) begin
          res.bad = 1'b1;
        end else begin
          res.word = mk_u(up_imm, rd, OPC_LUI);
        end
      end
      3'b100: begin
        case (h[11:10])
          2'b00: res.word = shr_word;
          2'b01: res.word = shr_word | 32'h4000_0000;
          2'b10: res.word = mk_i(simm12, rp_d, 3'b111, rp_d, OPC_IMM);
          default: begin
            if (!h[12]) begin
              case (h[6:5])
                2'b00:   res.word = mk_r(7'b0100000, rp_s, rp_d, 3'b000, rp_d, OPC_REG);
                2'b01:   res.word = mk_r(7'b0000000, rp_s, rp_d, 3'b100, rp_d, OPC_REG);
                2'b10:   res.word = mk_r(7'b0000000, rp_s, rp_d, 3'b110, rp_d, OPC_REG);
                default: res.word = mk_r(7'b0000000, rp_s, rp_d, 3'b111, rp_d, OPC_REG);
              endcase
            end else if (IS64 && h[6:5] == 2'b00) begin
              res.word = mk_r(7'b0100000, rp_s, rp_d, 3'b000, rp_d, OPC_REG32);
            end else if (IS64 && h[6:5] == 2'b01) begin
              res.word = mk_r(7'b0000000, rp_s, rp_d, 3'b000, rp_d, OPC_REG32);
            end else begin
              res.bad = 1'b1;
            end
          end
        endcase
      end
      3'b101: res.word = mk_j(j_off, 5'd0, OPC_JAL);
      3'b110: res.word = mk_b(b_off, 5'd0, rp_d, 3'b000, OPC_BR);
      default: res.word = mk_b(b_off, 5'd0, rp_d, 3'b001, OPC_BR);
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      // R11: arithmetic right shift carries bit 30
      p_sra_bit30_r11: assert (h[15:13] != 3'b100 || h[11:10] != 2'b01 || res.word[30]);
      // R10: wide register group is never legal in the 32-bit build
      p_wide_grp_r10: assert (IS64 || h[15:13] != 3'b100 || h[11:10] != 2'b11 || !h[12] || res.bad);
      // R6: upper-immediate form never targets x0 or x2
      p_lui_dest_r6: assert (res.bad || res.word[6:0] != OPC_LUI ||
                             (res.word[11:7] != 5'd0 && res.word[11:7] != 5'd2));
    end
  end

endmodule

// File: rtl/cx_quad2.sv
module cx_quad2 import cx_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [CLEN-1:2] h,
  output cx_res_t         res
);
  localparam bit IS64 = (XLEN == 64);

  logic [RW-1:0] rd, rs2;
  logic [11:0]   lw_off, ld_off, sw_off, sd_off;

  assign rd     = h[11:7];
  assign rs2    = h[6:2];
  assign lw_off = {4'b0, h[3:2], h[12], h[6:4], 2'b00};
  assign ld_off = {3'b0, h[4:2], h[12], h[6:5], 3'b000};
  assign sw_off = {4'b0, h[8:7], h[12:9], 2'b00};
  assign sd_off = {3'b0, h[9:7], h[12:10], 3'b000};

  always_comb begin
    res = '{word: '0, bad: 1'b0};
    case (h[15:13])
      3'b000: if (rd == '0) res.bad = 1'b1;
              else res.word = mk_i({6'b0, h[12], h[6:2]}, rd, 3'b001, rd, OPC_IMM);
      3'b001: res.word = mk_i(ld_off, 5'd2, 3'b011, rd, OPC_LOADF);
      3'b010: if (rd == '0) res.bad = 1'b1;
              else res.word = mk_i(lw_off, 5'd2, 3'b010, rd, OPC_LOAD);
      3'b011: begin
        if (IS64) begin
          if (rd == '0) res.bad = 1'b1;
          else res.word = mk_i(ld_off, 5'd2, 3'b011, rd, OPC_LOAD);
        end else begin
          res.word = mk_i(lw_off, 5'd2, 3'b010, rd, OPC_LOADF);
        end
      end
      3'b100: begin
        if (rs2 == '0) begin
          if (!h[12]) begin
            if (rd == '0) res.bad = 1'b1;
            else res.word = mk_i(12'd0, rd, 3'b000, 5'd0, OPC_JALR);
          end else if (rd == '0) begin
            res.word = BREAK_WORD;
          end else begin
            res.word = mk_i(12'd0, rd, 3'b000, 5'd1, OPC_JALR);
          end
        end else if (rd == '0) begin
          res.bad = 1'b1;
        end else begin
          res.word = mk_r(7'b0, rs2, h[12] ? rd : 5'd0, 3'b000, rd, OPC_REG);
        end
      end
      3'b101: res.word = mk_s(sd_off, rs2, 5'd2, 3'b011, OPC_STOREF);
      3'b110: res.word = mk_s(sw_off, rs2, 5'd2, 3'b010, OPC_STORE);
      default: begin
        if (IS64) res.word = mk_s(sd_off, rs2, 5'd2, 3'b011, OPC_STORE);
        else      res.word = mk_s(sw_off, rs2, 5'd2, 3'b010, OPC_STOREF);
      end
    endcase
  end

  always_comb begin
    if (!$isunknown(h)) begin
      // R9: the break encoding appears only for the rd = x0, rs2 = 0, bit12 = 1 slot
      p_break_slot_r9: assert ((res.word == BREAK_WORD) ==
                               (h[15:13] == 3'b100 && h[12] && rd == '0 && rs2 == '0));
      // R12: legal loads from the stack never write x0 in the integer file
      p_load_dest_r12: assert (res.bad || res.word[6:0] != OPC_LOAD || res.word[11:7] != '0);
    end
  end

endmodule

// File: rtl/cinst_expand.sv
module cinst_expand import cx_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [31:0] cword_i,
  output logic [31:0] xword_o,
  output logic [2:0]  len_o,
  output logic        bad_o
);
  localparam int unsigned NQ = 3;
  localparam logic [2:0] LEN_FULL = 3'd4;
  localparam logic [2:0] LEN_HALF = 3'd2;

  cx_res_t qres [NQ];

  cx_quad0 #(.XLEN(XLEN)) u_q0 (.h(cword_i[CLEN-1:2]), .res(qres[0]));
  cx_quad1 #(.XLEN(XLEN)) u_q1 (.h(cword_i[CLEN-1:2]), .res(qres[1]));
  cx_quad2 #(.XLEN(XLEN)) u_q2 (.h(cword_i[CLEN-1:2]), .res(qres[2]));

  always_comb begin
    if (cword_i[1:0] == 2'b11) begin
      xword_o = cword_i;
      len_o   = LEN_FULL;
      bad_o   = 1'b0;
    end else begin
      xword_o = qres[cword_i[1:0]].word;
      len_o   = LEN_HALF;
      bad_o   = qres[cword_i[1:0]].bad;
    end
  end

  always_comb begin
    if (!$isunknown(cword_i)) begin
      p_pass_r1: assert (cword_i[1:0] != 2'b11 ||
                         (xword_o == cword_i && len_o == LEN_FULL && !bad_o));
      p_half_len_r2: assert (cword_i[1:0] == 2'b11 || len_o == LEN_HALF);
      p_bad_zero_r2: assert (!bad_o || xword_o == '0);
      p_full_form_r2: assert (bad_o || xword_o[1:0] == 2'b11);
    end
  end

endmodule

// File: tb/sim_cinst_expand.sv
module sim_cinst_expand;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] stim;
  logic [31:0] w32, w64;
  logic [2:0]  l32, l64;
  logic        b32, b64;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cinst_expand #(.XLEN(32)) u0 (.cword_i(stim), .xword_o(w32), .len_o(l32), .bad_o(b32));
  cinst_expand #(.XLEN(64)) u1 (.cword_i(stim), .xword_o(w64), .len_o(l64), .bad_o(b64));

  function automatic logic [31:0] fi(int imm, int rs1, int f3, int rd, int op);
    return 32'(((imm & 'hFFF) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction
  function automatic logic [31:0] fs(int imm, int rs2, int rs1, int f3, int op);
    return 32'((((imm >> 5) & 'h7F) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) |
               ((imm & 'h1F) << 7) | op);
  endfunction
  function automatic logic [31:0] fr(int f7, int rs2, int rs1, int f3, int rd, int op);
    return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
  endfunction
  function automatic logic [31:0] fj(int off, int rd, int op);
    logic [31:0] u;
    u = 32'(off);
    return {u[20], u[10:1], u[11], u[19:12], 5'(rd), 7'(op)};
  endfunction
  function automatic logic [31:0] fb(int off, int rs1, int f3);
    logic [31:0] u;
    u = 32'(off);
    return {u[12], u[10:5], 5'd0, 5'(rs1), 3'(f3), u[4:1], u[11], 7'h63};
  endfunction

  // returns {illegal, word}
  function automatic logic [32:0] model(logic [31:0] w, bit x64);
    logic [15:0] h;
    int q, f, rd, r2, pd, ps, s6, u6, wo, dO, jo, bo, so;
    h  = w[15:0];
    if (h[1:0] == 2'b11) return {1'b0, w};
    q  = int'(h[1:0]);  f = int'(h[15:13]);
    rd = int'(h[11:7]); r2 = int'(h[6:2]);
    pd = 8 + int'(h[9:7]); ps = 8 + int'(h[4:2]);
    u6 = int'({h[12], h[6:2]});
    s6 = u6 - (h[12] ? 64 : 0);
    jo = int'(h[5:3]) * 2 + int'(h[11]) * 16 + int'(h[2]) * 32 + int'(h[7]) * 64 +
         int'(h[6]) * 128 + int'(h[10:9]) * 256 + int'(h[8]) * 1024 - (h[12] ? 2048 : 0);
    bo = int'(h[4:3]) * 2 + int'(h[11:10]) * 8 + int'(h[2]) * 32 + int'(h[5]) * 64 +
         int'(h[6]) * 128 - (h[12] ? 256 : 0);
    if (q == 0) begin
      wo = int'(h[6]) * 4 + int'(h[12:10]) * 8 + int'(h[5]) * 64;
      dO = int'(h[12:10]) * 8 + int'(h[6:5]) * 64;
      case (f)
        0: begin
          so = int'(h[6]) * 4 + int'(h[5]) * 8 + int'(h[12:11]) * 16 + int'(h[10:7]) * 64;
          if (so == 0) return {1'b1, 32'h0};
          return {1'b0, fi(so, 2, 0, ps, 'h13)};
        end
        1: return {1'b0, fi(dO, pd, 3, ps, 'h07)};
        2: return {1'b0, fi(wo, pd, 2, ps, 'h03)};
        3: return x64 ? {1'b0, fi(dO, pd, 3, ps, 'h03)} : {1'b0, fi(wo, pd, 2, ps, 'h07)};
        5: return {1'b0, fs(dO, ps, pd, 3, 'h27)};
        6: return {1'b0, fs(wo, ps, pd, 2, 'h23)};
        7: return x64 ? {1'b0, fs(dO, ps, pd, 3, 'h23)} : {1'b0, fs(wo, ps, pd, 2, 'h27)};
        default: return {1'b1, 32'h0};
      endcase
    end else if (q == 1) begin
      case (f)
        0: return {1'b0, fi(s6, rd, 0, rd, 'h13)};
        1: begin
          if (!x64) return {1'b0, fj(jo, 1, 'h6F)};
          if (rd == 0) return {1'b1, 32'h0};
          return {1'b0, fi(s6, rd, 0, rd, 'h1B)};
        end
        2: return {1'b0, fi(s6, 0, 0, rd, 'h13)};
        3: begin
          if (rd == 2) begin
            so = int'(h[6]) * 16 + int'(h[2]) * 32 + int'(h[5]) * 64 + int'(h[4:3]) * 128 -
                 (h[12] ? 512 : 0);
            if (so == 0) return {1'b1, 32'h0};
            return {1'b0, fi(so, 2, 0, 2, 'h13)};
          end
          if (rd == 0 || s6 == 0) return {1'b1, 32'h0};
          return {1'b0, 32'((s6 & 'hFFFFF) << 12) | 32'((rd << 7) | 'h37)};
        end
        4: begin
          case (int'(h[11:10]))
            0: return {1'b0, fi(u6, pd, 5, pd, 'h13)};
            1: return {1'b0, fi(u6 + 1024, pd, 5, pd, 'h13)};
            2: return {1'b0, fi(s6, pd, 7, pd, 'h13)};
            default: begin
              if (!h[12]) begin
                case (int'(h[6:5]))
                  0: return {1'b0, fr(32, ps, pd, 0, pd, 'h33)};
                  1: return {1'b0, fr(0, ps, pd, 4, pd, 'h33)};
                  2: return {1'b0, fr(0, ps, pd, 6, pd, 'h33)};
                  default: return {1'b0, fr(0, ps, pd, 7, pd, 'h33)};
                endcase
              end
              if (x64 && h[6:5] == 2'b00) return {1'b0, fr(32, ps, pd, 0, pd, 'h3B)};
              if (x64 && h[6:5] == 2'b01) return {1'b0, fr(0, ps, pd, 0, pd, 'h3B)};
              return {1'b1, 32'h0};
            end
          endcase
        end
        5: return {1'b0, fj(jo, 0, 'h6F)};
        6: return {1'b0, fb(bo, pd, 0)};
        default: return {1'b0, fb(bo, pd, 1)};
      endcase
    end else begin
      wo = int'(h[6:4]) * 4 + int'(h[12]) * 32 + int'(h[3:2]) * 64;
      dO = int'(h[6:5]) * 8 + int'(h[12]) * 32 + int'(h[4:2]) * 64;
      case (f)
        0: return (rd == 0) ? {1'b1, 32'h0} : {1'b0, fi(u6, rd, 1, rd, 'h13)};
        1: return {1'b0, fi(dO, 2, 3, rd, 'h07)};
        2: return (rd == 0) ? {1'b1, 32'h0} : {1'b0, fi(wo, 2, 2, rd, 'h03)};
        3: begin
          if (!x64) return {1'b0, fi(wo, 2, 2, rd, 'h07)};
          return (rd == 0) ? {1'b1, 32'h0} : {1'b0, fi(dO, 2, 3, rd, 'h03)};
        end
        4: begin
          if (r2 == 0) begin
            if (!h[12]) return (rd == 0) ? {1'b1, 32'h0} : {1'b0, fi(0, rd, 0, 0, 'h67)};
            return (rd == 0) ? {1'b0, 32'h0010_0073} : {1'b0, fi(0, rd, 0, 1, 'h67)};
          end
          if (rd == 0) return {1'b1, 32'h0};
          return {1'b0, fr(0, r2, h[12] ? rd : 0, 0, rd, 'h33)};
        end
        5: return {1'b0, fs(int'(h[12:10]) * 8 + int'(h[9:7]) * 64, r2, 2, 3, 'h27)};
        6: return {1'b0, fs(int'(h[12:9]) * 4 + int'(h[8:7]) * 64, r2, 2, 2, 'h23)};
        default: begin
          if (x64) return {1'b0, fs(int'(h[12:10]) * 8 + int'(h[9:7]) * 64, r2, 2, 3, 'h23)};
          return {1'b0, fs(int'(h[12:9]) * 4 + int'(h[8:7]) * 64, r2, 2, 2, 'h27)};
        end
      endcase
    end
  endfunction

  function automatic string tag_of(logic [15:0] h);
    if (h[1:0] == 2'b11) return "R1";
    case ({h[1:0], h[15:13]})
      5'b00_000: return "R4";
      5'b00_100: return "R2";
      5'b00_011, 5'b00_111, 5'b10_011, 5'b10_111: return "R5";
      5'b01_011: return "R6";
      5'b01_001, 5'b01_101: return "R7";
      5'b01_110, 5'b01_111: return "R8";
      5'b10_100: return "R9";
      5'b10_000, 5'b10_010: return "R12";
      5'b01_100: begin
        if (h[11:10] == 2'b01) return "R11";
        if (h[11:10] == 2'b11 && h[12]) return "R10";
        return "R14";
      end
      5'b01_000, 5'b01_010: return "R14";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h (input %h)", tag, what, act, exp, stim);
    end
  endtask

  task automatic check_both();
    logic [32:0] e32, e64;
    string t;
    e32 = model(stim, 1'b0);
    e64 = model(stim, 1'b1);
    t = tag_of(stim[15:0]);
    chk(t, "word xlen32", w32, e32[31:0]);
    chk(t, "illegal xlen32", {31'b0, b32}, {31'b0, e32[32]});
    chk(t, "word xlen64", w64, e64[31:0]);
    chk(t, "illegal xlen64", {31'b0, b64}, {31'b0, e64[32]});
    chk((stim[1:0] == 2'b11) ? "R1" : "R2", "length", {29'b0, l32, l64[0]},
        {29'b0, (stim[1:0] == 2'b11) ? 3'd4 : 3'd2, 1'b0});
    chk((stim[1:0] == 2'b11) ? "R1" : "R2", "length xlen64", {29'b0, l64},
        {29'b0, (stim[1:0] == 2'b11) ? 3'd4 : 3'd2});
  endtask

  initial begin
    stim = 32'h0000_0013;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: a full-length word at release
    @(negedge clk);
    chk("R1", "idle word", w32, 32'h0000_0013);
    // R3: compressed register fields in both positions (AND form)
    for (int r = 0; r < 8; r++) begin
      @(posedge clk);
      #2 stim = {16'hFFFF, 3'b100, 1'b0, 2'b11, 3'(r), 2'b11, 3'(7 - r), 2'b01};
      @(negedge clk);
      chk("R3", "dest field", {27'b0, w32[11:7]}, 32'(8 + r));
      chk("R3", "source field", {27'b0, w64[24:20]}, 32'(15 - r));
    end
    // R1, R2, R4..R14: every low halfword, upper half varied
    for (int p = 0; p < 65536; p++) begin
      logic [15:0] lo;
      lo = 16'(p);
      @(posedge clk);
      #2 stim = {lo ^ 16'hA53C ^ {lo[7:0], lo[15:8]}, lo};
      @(negedge clk);
      check_both();
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule